// File: doc/BRIEF.md
# Slot Interrupt Router

The router turns an interrupt event from a bus device into activity on one interrupt wire toward the processor. Each event names the slot the device sits in and which of its four interrupt pins (A to D, coded 0 to 3) changed. A fixed slot-dependent swizzle turns the pair into an internal line number. Internal line numbers start at a base of 32. The line's offset from that base selects one bit in each of two 32-bit configuration words: a trigger-mode word and a polarity word.

When the trigger-mode bit is set, the event produces a pulse on the output that lasts exactly one clock. When it is clear, the output is driven to the line's polarity bit and held there until the next routed event. An event whose computed number lies below the base leaves the output untouched.

Events arrive on a valid/ready handshake. `evt_ready` is low while reset is asserted and rises on the first clock after reset is released. From then on it stays high, so the block never applies back-pressure. An event is taken on a rising edge where both `evt_valid` and `evt_ready` are high. The slot and pin fields must be stable while `evt_valid` is high. The configuration words are plain inputs and are sampled on the same edge as the event.

Top module: `irq_slot_router`

## Requirements
- R1: While `rst_n` is low, `irq_out` and `evt_ready` are 0. `evt_ready` is 1 from the first rising edge after reset release onward.
- R2: An event is taken only on a rising edge with `evt_valid` and `evt_ready` both high. The output reflects it after that same edge. With `evt_valid` low, configuration changes do not move the output.
- R3: Slot 5, pin n (0..3) routes to line base+n, which is bit n of the configuration words.
- R4: Slot 6 routes every pin to bit 4. Slot 7 routes every pin to bit 5.
- R5: Slots 8 to 12 route pin n to bit 6+(slot-8)+n, which covers bits 6 to 13.
- R6: Any other slot (0 to 4, or 13 to 31) yields the raw pin number, which is below the base of 32. Such an event leaves `irq_out` unchanged.
- R7: If `edge_cfg[bit]` is 1, a taken event drives `irq_out` high for exactly one clock. It stays high only while further edge-mode events are taken on consecutive edges.
- R8: If `edge_cfg[bit]` is 0, a taken event sets `irq_out` to `pol_cfg[bit]`. The output holds that value until the next routed event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | An interrupt event is offered |
| evt_ready | output | 1 | Router accepts events (high after reset) |
| evt_slot | input | 5 | Slot number of the signalling device |
| evt_pin | input | 2 | Interrupt pin, 0=A .. 3=D |
| edge_cfg | input | 32 | Per-line trigger mode, 1 = pulse, 0 = level |
| pol_cfg | input | 32 | Per-line level value used in level mode |
| irq_out | output | 1 | Interrupt wire toward the processor |

## Verification
The hardest behaviour to observe from the ports is an event that must do nothing. A silent output looks the same whether a pass-through event was ignored or the routing is simply broken. The stimulus first drives the output high through a known level-mode line. It then switches both configuration words to values that would pull the output low or pulse it, and offers the unrouted event. Any reaction to that event becomes visible. The exact pulse width is checked the same way: consecutive edge-mode events are offered, and the bench confirms that the output drops on the first clock without one.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int LINE_IDX_W = 5;
  localparam int CFG_W      = 1 << LINE_IDX_W;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;

  typedef struct packed {
    logic                  ok;
    logic [LINE_IDX_W-1:0] idx;
  } route_t;
endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map
  import irq_route_pkg::*;
#(
  parameter int SLOT_W      = 5,
  parameter int PIN_W       = 2,
  parameter int LINE_BASE   = 32,
  parameter int SHARED_SLOT = 5,
  parameter int VIDEO_SLOT  = 6,
  parameter int VIDEO_LINE  = 4,
  parameter int NIC_SLOT    = 7,
  parameter int NIC_LINE    = 5,
  parameter int EXP_FIRST   = 8,
  parameter int EXP_LAST    = 12,
  parameter int EXP_LINE0   = 6
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [PIN_W-1:0]  pin_i,
  output route_t            route_o
);
  localparam int EXP_N    = EXP_LAST - EXP_FIRST + 1;
  localparam int PIN_SPAN = 1 << PIN_W;

  logic [EXP_N-1:0] exp_hit;
  int               off_c;
  logic             fixed_c;

  // one comparator per expansion slot
  for (genvar g = 0; g < EXP_N; g++) begin : g_exp
    assign exp_hit[g] = (slot_i == SLOT_W'(EXP_FIRST + g));
  end

  always_comb begin
    fixed_c = 1'b1;
    off_c   = 0;
    if (slot_i == SLOT_W'(SHARED_SLOT)) begin
      off_c = int'(pin_i) % PIN_SPAN;
    end else if (slot_i == SLOT_W'(VIDEO_SLOT)) begin
      off_c = VIDEO_LINE;
    end else if (slot_i == SLOT_W'(NIC_SLOT)) begin
      off_c = NIC_LINE;
    end else if (|exp_hit) begin
      for (int g = 0; g < EXP_N; g++) begin
        if (exp_hit[g]) off_c = EXP_LINE0 + g + int'(pin_i);
      end
    end else begin
      // untranslated: the raw pin is the line number, offset by base
      fixed_c = 1'b0;
      off_c   = int'(pin_i) - LINE_BASE;
    end
    route_o.ok  = (off_c >= 0) && (off_c < CFG_W) &&
                  (fixed_c || (int'(pin_i) >= LINE_BASE));
    route_o.idx = LINE_IDX_W'(off_c);
  end
endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive
  import irq_route_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hit_i,
  input  trig_e mode_i,
  input  logic  pol_i,
  output logic  irq_o
);
  logic irq_q;
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (hit_i) begin
      if (mode_i == TRIG_EDGE) begin
        irq_q   <= 1'b1;
        pulse_q <= 1'b1;
      end else begin
        irq_q   <= pol_i;
        pulse_q <= 1'b0;
      end
    end else if (pulse_q) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  AST_EDGE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && mode_i == TRIG_EDGE) |=> irq_o); // R7
  AST_PULSE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && !hit_i) |=> !irq_o); // R7
  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && mode_i == TRIG_LEVEL) |=> (irq_o == $past(pol_i))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_i && !pulse_q) |=> $stable(irq_o)); // R6
endmodule

// File: rtl/irq_slot_router.sv
module irq_slot_router
  import irq_route_pkg::*;
#(
  parameter int SLOT_W    = 5,
  parameter int PIN_W     = 2,
  parameter int LINE_BASE = 32,
  parameter int EXP_FIRST = 8,
  parameter int EXP_LAST  = 12,
  parameter int EXP_LINE0 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [SLOT_W-1:0] evt_slot,
  input  logic [PIN_W-1:0]  evt_pin,
  input  logic [CFG_W-1:0]  edge_cfg,
  input  logic [CFG_W-1:0]  pol_cfg,
  output logic              irq_out
);
  route_t route;
  logic   ready_q;
  logic   take;
  logic   hit;
  trig_e  mode;
  logic   pol_bit;

  irq_slot_map #(
    .SLOT_W    (SLOT_W),
    .PIN_W     (PIN_W),
    .LINE_BASE (LINE_BASE),
    .EXP_FIRST (EXP_FIRST),
    .EXP_LAST  (EXP_LAST),
    .EXP_LINE0 (EXP_LINE0)
  ) u_map (
    .slot_i  (evt_slot),
    .pin_i   (evt_pin),
    .route_o (route)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign evt_ready = ready_q;
  assign take      = evt_valid && ready_q;
  assign hit       = take && route.ok;
  assign mode      = trig_e'(edge_cfg[route.idx]);
  assign pol_bit   = pol_cfg[route.idx];

  irq_line_drive u_drive (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (hit),
    .mode_i (mode),
    .pol_i  (pol_bit),
    .irq_o  (irq_out)
  );

  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ready |=> evt_ready); // R1
  AST_VIDEO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_slot == SLOT_W'(6)) |-> (route.ok && route.idx == 5'd4)); // R4
  AST_EXP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_slot >= SLOT_W'(EXP_FIRST) && evt_slot <= SLOT_W'(EXP_LAST))
      |-> (route.ok && route.idx >= 5'(EXP_LINE0))); // R5
  AST_SHARED_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_slot == SLOT_W'(5)) |-> (route.ok && route.idx == 5'(evt_pin))); // R3
endmodule

// File: tb/tb_irq_slot_router.sv
`timescale 1ns/1ps
module tb_irq_slot_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [4:0]  evt_slot = '0;
  logic [1:0]  evt_pin = '0;
  logic [31:0] edge_cfg = '0;
  logic [31:0] pol_cfg = '0;
  logic        irq_out;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_slot_router dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_slot(evt_slot), .evt_pin(evt_pin), .edge_cfg(edge_cfg),
    .pol_cfg(pol_cfg), .irq_out(irq_out)
  );

  // {slot, pin, expected bit}; bit 63 marks an unrouted event
  localparam logic [12:0] VEC [15] = '{
    {5'd5, 2'd0, 6'd0},  {5'd5, 2'd3, 6'd3},  {5'd6, 2'd0, 6'd4},
    {5'd6, 2'd2, 6'd4},  {5'd7, 2'd1, 6'd5},  {5'd7, 2'd3, 6'd5},
    {5'd8, 2'd0, 6'd6},  {5'd8, 2'd3, 6'd9},  {5'd10, 2'd1, 6'd9},
    {5'd12, 2'd0, 6'd10}, {5'd12, 2'd3, 6'd13}, {5'd0, 2'd2, 6'd63},
    {5'd4, 2'd1, 6'd63}, {5'd13, 2'd0, 6'd63}, {5'd31, 2'd3, 6'd63}
  };

  task automatic chk(input logic got, input logic exp, input string req);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // call at a negedge; returns at the negedge after the accepting edge
  task automatic send(input logic [4:0] s, input logic [1:0] p);
    evt_slot  = s;
    evt_pin   = p;
    evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  function automatic string req_of(input logic [4:0] s);
    if (s == 5'd5) return "R3";
    if (s == 5'd6 || s == 5'd7) return "R4";
    return "R5";
  endfunction

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(irq_out, 1'b0, "R1 irq in reset");
    chk(evt_ready, 1'b0, "R1 ready in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(evt_ready, 1'b1, "R1 ready after reset");

    // table walk
    for (int i = 0; i < 15; i++) begin
      logic [4:0] s;
      logic [1:0] p;
      logic [5:0] e;
      s = VEC[i][12:8];
      p = VEC[i][7:6];
      e = VEC[i][5:0];
      if (e != 6'd63) begin
        edge_cfg = '0;
        pol_cfg  = 32'd1 << e;
        send(s, p);
        chk(irq_out, 1'b1, req_of(s));
        pol_cfg = ~(32'd1 << e);
        send(s, p);
        chk(irq_out, 1'b0, req_of(s));
      end else begin
        edge_cfg = '0;
        pol_cfg  = 32'd1;
        send(5'd5, 2'd0);
        pol_cfg  = '0;
        edge_cfg = '1;
        send(s, p);
        chk(irq_out, 1'b1, "R6 unrouted slot");
        @(negedge clk);
        chk(irq_out, 1'b1, "R6 unrouted no pulse");
      end
    end

    // R8 / R2: level holds, config changes without valid do nothing
    edge_cfg = '0;
    pol_cfg  = 32'd1 << 7;
    send(5'd9, 2'd0);  // bit 7
    pol_cfg  = '0;
    edge_cfg = '1;
    repeat (3) @(negedge clk);
    chk(irq_out, 1'b1, "R8 level held");
    chk(irq_out, 1'b1, "R2 no event without valid");

    // R7: single pulse, bit 11 (slot 11 pin 2)
    send(5'd5, 2'd0);  // edge on bit 0: pulse
    @(negedge clk);
    edge_cfg = 32'd1 << 11;
    pol_cfg  = '1;
    send(5'd11, 2'd2);
    chk(irq_out, 1'b1, "R7 pulse high");
    @(negedge clk);
    chk(irq_out, 1'b0, "R7 pulse one clock");
    @(negedge clk);
    chk(irq_out, 1'b0, "R7 pulse stays low");

    // R7: back-to-back edge events
    evt_slot = 5'd11; evt_pin = 2'd2; evt_valid = 1'b1;
    @(negedge clk);
    chk(irq_out, 1'b1, "R7 back-to-back first");
    @(negedge clk);
    evt_valid = 1'b0;
    chk(irq_out, 1'b1, "R7 back-to-back second");
    @(negedge clk);
    chk(irq_out, 1'b0, "R7 back-to-back end");

    // R6/R7: unrouted event during pulse does not extend it
    send(5'd11, 2'd2);
    send(5'd2, 2'd1);
    chk(irq_out, 1'b0, "R6 unrouted during pulse");

    // R8: level low after pulse, then polarity set pulls high
    edge_cfg = '0;
    pol_cfg  = 32'd1 << 13;
    send(5'd12, 2'd3);
    chk(irq_out, 1'b1, "R8 level high bit 13");
    @(negedge clk);
    chk(irq_out, 1'b1, "R8 level held bit 13");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule